// File: doc/BRIEF.md
# Strand Steering Dispatcher

This block sits between the decode/rename front end and a set of simple in-order processing elements. It receives one decoded instruction per cycle, in program order. Each instruction carries a logical accumulator number, a flag that marks it as the first instruction of a dependence chain (a strand), a flag that marks it as the last instruction of that chain, and an opaque payload. The dispatcher writes every instruction of one strand into the same per-element FIFO. Within a FIFO the accumulator value passes from one instruction to the next, so no wakeup or select logic is needed.

A table indexed by logical accumulator records which FIFO holds the strand that is currently live on that accumulator. When a strand starts, the table entry is claimed. Later members of the strand look up the entry to find their FIFO. The entry is released when the strand's closing instruction issues, unless a newer strand has claimed the accumulator in the meantime. A FIFO that still holds instructions can take a new strand only if the last instruction written into it closed its strand.

Each FIFO shows only its head entry to its processing element and pops that entry when the element's ready is high. A flush clears all FIFOs, the table and the error flag in one cycle.

Top module: `strand_steer`

## Requirements
- R1: After reset, and in the cycle after a cycle with `flush` high, every `iss_valid` bit is 0 and `map_err` is 0. The accumulator table is empty, so a non-start instruction for any accumulator is then dropped as unmapped.
- R2: A strand-start instruction (`in_start`=1) goes to the lowest-numbered FIFO that is empty. While any FIFO is empty and `flush` is low, a presented start is accepted (`in_ready`=1).
- R3: If no FIFO is empty, a start goes to the lowest-numbered FIFO that is not full and whose last written instruction had `in_end`=1. If there is no such FIFO, `in_ready` is 0 and nothing is written.
- R4: A non-start instruction whose accumulator has a live table entry goes to the FIFO recorded by that entry. That FIFO is the one that took the strand's start.
- R5: FIFO q shows its oldest entry's payload on `iss_payload[q*PW +: PW]`, with `iss_valid[q]`=1 while the FIFO is not empty. The entry is popped on a clock edge where `iss_valid[q]` and `iss_ready[q]` are both 1. When `iss_ready[q]` is 0, the head holds. Entries leave each FIFO in the order they were written.
- R6: A FIFO is full when it holds DEPTH entries at the start of the cycle. An instruction whose target FIFO is full sees `in_ready`=0, even if the head of that FIFO pops in the same cycle.
- R7: A non-start instruction with no live table entry is taken (`in_ready`=1) and discarded. It sets `map_err`, which stays at 1 until reset or flush.
- R8: When an entry with `in_end`=1 pops, the table entry of its accumulator is released, unless a start on that accumulator has been accepted after the popped entry was written. A start accepted in the same cycle as the pop keeps its new mapping. A non-start accepted in that cycle still uses the old mapping.
- R9: While `flush` is 1, `in_ready` is 0 and no FIFO pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clears all FIFOs, the accumulator table and the error flag |
| in_valid | input | 1 | An instruction is presented |
| in_acc | input | ACC_W | Logical accumulator number |
| in_start | input | 1 | Instruction begins a strand |
| in_end | input | 1 | Instruction ends its strand |
| in_payload | input | PW | Opaque instruction payload |
| in_ready | output | 1 | Presented instruction is taken this cycle |
| iss_ready | input | NUM_Q | Per-element ready to take the head entry |
| iss_valid | output | NUM_Q | Per-FIFO head entry present |
| iss_payload | output | NUM_Q*PW | Head payloads, lane q at bits q*PW upward |
| map_err | output | 1 | Sticky: an unmapped non-start was dropped |

## Verification
The conflict of interest is a cycle in which a strand's closing instruction pops from one FIFO while a new instruction on the same accumulator is being steered. A start in that cycle must keep the fresh mapping, so a later follower reaches the new FIFO without an error. A follower in that cycle must still use the old mapping. A directed sequence parks a single-instruction strand at a FIFO head and then raises that element's ready in the same cycle as a new start on that accumulator. Random traffic, with sparse ready and mostly-start stimulus on a small set of accumulators, produces many more such cycles. A reference model in the bench makes its steering decision from the state before the cycle, applies pops, and then applies the write. Its map release matches on a global strand serial number, not on the design's epoch field. Payloads, valids, `in_ready` and `map_err` are compared every cycle.

// File: rtl/strand_pkg.sv
// Shared types for the strand steering dispatcher.
package strand_pkg;
    // What happens to the instruction presented in the current cycle.
    typedef enum logic [1:0] {
        DISP_NONE   = 2'd0,  // nothing taken
        DISP_START  = 2'd1,  // new strand claims a FIFO
        DISP_FOLLOW = 2'd2,  // member of a live strand
        DISP_DROP   = 2'd3   // unmapped follower, discarded
    } disp_kind_e;
endpackage

// File: rtl/sq_fifo.sv
// Per-element in-order FIFO. Shows its oldest entry and remembers the mark
// bit of the most recently written entry.
// Assumes: DEPTH is a power of two; caller never pushes when full nor pops
// when empty; clr wins over push and pop.
module sq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         push_mark,
    input  logic         pop,
    output logic         empty,
    output logic         full,
    output logic [W-1:0] head,
    output logic         tail_mark
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;

    // Storage write; contents need no reset since cnt guards reads.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer, occupancy and tail-mark bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr    <= '0;
            wr_ptr    <= '0;
            cnt       <= '0;
            tail_mark <= 1'b0;
        end else begin
            if (push) begin
                wr_ptr    <= wr_ptr + 1'b1;
                tail_mark <= push_mark;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Status and head view.
    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == CNT_W'(DEPTH));
        head  = mem[rd_ptr];
    end
endmodule

// File: rtl/sq_pick.sv
// Fixed-priority picker: index of the lowest set request bit.
// Assumes: N >= 2.
module sq_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // Scan from the top so the lowest set bit is the last to win.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/strand_steer.sv
// Strand steering dispatcher: routes each in-order instruction into a
// per-element FIFO chosen by accumulator identity, and offers FIFO heads to
// in-order issue. A table per logical accumulator holds {live, fifo, epoch};
// the epoch is stamped into each entry so that a closing entry releases the
// table only if no newer strand has claimed the accumulator.
// Assumes: NUM_Q >= 2, DEPTH a power of two, one instruction per cycle,
// and fewer than 2**EPOCH_W starts on one accumulator while an older
// closing entry of that accumulator waits in a FIFO.
module strand_steer
    import strand_pkg::*;
#(
    parameter int NUM_Q   = 4,
    parameter int DEPTH   = 8,
    parameter int ACC_W   = 3,
    parameter int PW      = 16,
    parameter int EPOCH_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                in_valid,
    input  logic [ACC_W-1:0]    in_acc,
    input  logic                in_start,
    input  logic                in_end,
    input  logic [PW-1:0]       in_payload,
    output logic                in_ready,
    input  logic [NUM_Q-1:0]    iss_ready,
    output logic [NUM_Q-1:0]    iss_valid,
    output logic [NUM_Q*PW-1:0] iss_payload,
    output logic                map_err
);
    localparam int QI_W  = $clog2(NUM_Q);
    localparam int N_ACC = 1 << ACC_W;
    localparam int ENT_W = PW + ACC_W + 1 + EPOCH_W;
    localparam int END_B = EPOCH_W;
    localparam int ACC_B = EPOCH_W + 1;
    localparam int PL_B  = EPOCH_W + 1 + ACC_W;

    // Accumulator table.
    logic               map_v  [N_ACC];
    logic [QI_W-1:0]    map_q  [N_ACC];
    logic [EPOCH_W-1:0] map_ep [N_ACC];

    // FIFO side.
    logic [NUM_Q-1:0] q_empty, q_full, q_tmark, q_push, q_pop;
    logic [ENT_W-1:0] q_head [NUM_Q];
    logic [ACC_W-1:0] h_acc  [NUM_Q];
    logic [EPOCH_W-1:0] h_ep [NUM_Q];
    logic [NUM_Q-1:0] h_end;

    // Steering decision.
    logic             any_empty, any_reuse;
    logic [QI_W-1:0]  idx_empty, idx_reuse, tgt_q;
    logic             hit;
    logic [EPOCH_W-1:0] wr_ep;
    logic [ENT_W-1:0] wr_ent;
    disp_kind_e       kind;

    sq_pick #(.N(NUM_Q)) pick_empty_i (
        .req(q_empty), .any(any_empty), .idx(idx_empty)
    );
    sq_pick #(.N(NUM_Q)) pick_reuse_i (
        .req(q_tmark & ~q_full), .any(any_reuse), .idx(idx_reuse)
    );

    // Choose the target FIFO and classify the presented instruction.
    always_comb begin
        hit      = map_v[in_acc];
        tgt_q    = in_start ? (any_empty ? idx_empty : idx_reuse) : map_q[in_acc];
        wr_ep    = in_start ? map_ep[in_acc] + 1'b1 : map_ep[in_acc];
        wr_ent   = {in_payload, in_acc, in_end, wr_ep};
        if (flush)
            in_ready = 1'b0;
        else if (in_start)
            in_ready = any_empty || any_reuse;
        else
            in_ready = !hit || !q_full[tgt_q];
        if (!(in_valid && in_ready))
            kind = DISP_NONE;
        else if (in_start)
            kind = DISP_START;
        else if (hit)
            kind = DISP_FOLLOW;
        else
            kind = DISP_DROP;
    end

    // Decode the write strobe and pop strobes.
    always_comb begin
        q_push = '0;
        if (kind == DISP_START || kind == DISP_FOLLOW) q_push[tgt_q] = 1'b1;
        q_pop = iss_ready & ~q_empty & {NUM_Q{~flush}};
    end

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_q
            sq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) fifo_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (flush),
                .push      (q_push[q]),
                .push_data (wr_ent),
                .push_mark (in_end),
                .pop       (q_pop[q]),
                .empty     (q_empty[q]),
                .full      (q_full[q]),
                .head      (q_head[q]),
                .tail_mark (q_tmark[q])
            );
            // Split the head entry into its fields for issue and release.
            always_comb begin
                h_ep[q]  = q_head[q][EPOCH_W-1:0];
                h_end[q] = q_head[q][END_B];
                h_acc[q] = q_head[q][ACC_B +: ACC_W];
                iss_payload[q*PW +: PW] = q_head[q][PL_B +: PW];
            end
        end
    endgenerate

    assign iss_valid = ~q_empty;

    // Table update: release on closing pops, then claims from starts win.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int a = 0; a < N_ACC; a++) begin
                map_v[a]  <= 1'b0;
                map_q[a]  <= '0;
                map_ep[a] <= '0;
            end
        end else begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (q_pop[q] && h_end[q] && map_v[h_acc[q]] &&
                    map_q[h_acc[q]] == QI_W'(q) && map_ep[h_acc[q]] == h_ep[q])
                    map_v[h_acc[q]] <= 1'b0;
            end
            if (kind == DISP_START) begin
                map_v[in_acc]  <= 1'b1;
                map_q[in_acc]  <= tgt_q;
                map_ep[in_acc] <= wr_ep;
            end
        end
    end

    // Sticky error on a dropped unmapped follower.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) map_err <= 1'b0;
        else if (kind == DISP_DROP) map_err <= 1'b1;
    end
endmodule

// File: rtl/strand_steer_chk.sv
// Port-level properties of the strand steering dispatcher, bound to it.
module strand_steer_chk #(
    parameter int NUM_Q = 4,
    parameter int PW    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush,
    input logic                in_valid,
    input logic                in_start,
    input logic                in_ready,
    input logic [NUM_Q-1:0]    iss_ready,
    input logic [NUM_Q-1:0]    iss_valid,
    input logic [NUM_Q*PW-1:0] iss_payload,
    input logic                map_err
);
    // R9: nothing is accepted while a flush is applied.
    a_r9_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    // R1: a flush leaves every FIFO empty and the error flag clear.
    a_r1_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (iss_valid == '0) && !map_err);

    // R7: the error flag holds until reset or flush.
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (map_err && !flush) |=> map_err);

    // R2: any empty FIFO guarantees a start is taken.
    a_r2_start_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start && !flush && (iss_valid != {NUM_Q{1'b1}})) |-> in_ready);

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_hold
            // R5: a head that is not taken stays put.
            a_r5_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[q] && !iss_ready[q] && !flush) |=>
                    (iss_valid[q] && $stable(iss_payload[q*PW +: PW])));
        end
    endgenerate
endmodule

bind strand_steer strand_steer_chk #(.NUM_Q(NUM_Q), .PW(PW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .in_valid    (in_valid),
    .in_start    (in_start),
    .in_ready    (in_ready),
    .iss_ready   (iss_ready),
    .iss_valid   (iss_valid),
    .iss_payload (iss_payload),
    .map_err     (map_err)
);

// File: tb/strand_steer_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared every cycle against a reference model kept in the bench.
module strand_steer_tb_top;
    localparam int NQ = 4;
    localparam int D  = 8;
    localparam int AW = 3;
    localparam int NA = 1 << AW;
    localparam int PW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic [AW-1:0] in_acc = '0;
    logic in_start = 1'b0;
    logic in_end = 1'b0;
    logic [PW-1:0] in_payload = '0;
    logic in_ready;
    logic [NQ-1:0] iss_ready = '0;
    logic [NQ-1:0] iss_valid;
    logic [NQ*PW-1:0] iss_payload;
    logic map_err;

    always #4 clk = ~clk;

    strand_steer #(.NUM_Q(NQ), .DEPTH(D), .ACC_W(AW), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_acc(in_acc), .in_start(in_start),
        .in_end(in_end), .in_payload(in_payload), .in_ready(in_ready),
        .iss_ready(iss_ready), .iss_valid(iss_valid),
        .iss_payload(iss_payload), .map_err(map_err)
    );

    // Reference model state.
    int m_pl  [NQ][D];
    int m_acc [NQ][D];
    int m_ser [NQ][D];
    bit m_end [NQ][D];
    int m_cnt [NQ];
    bit m_tail[NQ];
    bit mp_v  [NA];
    int mp_q  [NA];
    int mp_ser[NA];
    bit m_err;
    int serial;
    int pl_ctr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int q = 0; q < NQ; q++) begin
            m_cnt[q] = 0;
            m_tail[q] = 1'b0;
        end
        for (int a = 0; a < NA; a++) begin
            mp_v[a] = 1'b0;
            mp_q[a] = 0;
            mp_ser[a] = 0;
        end
        m_err = 1'b0;
    endtask

    // Expected target of a start: lowest empty, else lowest reusable; -1 if none.
    function automatic int start_target();
        for (int q = 0; q < NQ; q++) if (m_cnt[q] == 0) return q;
        for (int q = 0; q < NQ; q++) if (m_tail[q] && m_cnt[q] < D) return q;
        return -1;
    endfunction

    // One cycle: drive, compare, advance the model, then take the edge.
    task automatic step(input bit fl, input bit v, input bit st, input bit en,
                        input int acc, input logic [NQ-1:0] rdy);
        int  tq;
        bit  exp_rdy, pre_hit;
        int  pre_ser;
        @(negedge clk);
        flush = fl; in_valid = v; in_start = st; in_end = en;
        in_acc = AW'(acc); iss_ready = rdy;
        pl_ctr++;
        in_payload = PW'(pl_ctr);
        #1;
        pre_hit = mp_v[acc];
        pre_ser = mp_ser[acc];
        tq = st ? start_target() : mp_q[acc];
        if (fl) exp_rdy = 1'b0;
        else if (st) exp_rdy = (tq >= 0);
        else exp_rdy = !pre_hit || (m_cnt[tq] < D);
        if (v) chk(in_ready == exp_rdy, "R2 R3 R6 R7 R9 in_ready", int'(in_ready), int'(exp_rdy));
        for (int q = 0; q < NQ; q++) begin
            chk(iss_valid[q] == (m_cnt[q] > 0), "R1 R5 iss_valid", int'(iss_valid[q]), int'(m_cnt[q] > 0));
            if (m_cnt[q] > 0)
                chk(int'(iss_payload[q*PW +: PW]) == m_pl[q][0], "R4 R5 iss_payload",
                    int'(iss_payload[q*PW +: PW]), m_pl[q][0]);
        end
        chk(map_err == m_err, "R1 R7 R8 map_err", int'(map_err), int'(m_err));
        if (fl) begin
            model_clear();
        end else begin
            // Pops first, with release matched on strand serial.
            for (int q = 0; q < NQ; q++) begin
                if (m_cnt[q] > 0 && rdy[q]) begin
                    if (m_end[q][0] && mp_v[m_acc[q][0]] && mp_ser[m_acc[q][0]] == m_ser[q][0])
                        mp_v[m_acc[q][0]] = 1'b0;
                    for (int i = 0; i < D - 1; i++) begin
                        m_pl[q][i] = m_pl[q][i+1]; m_acc[q][i] = m_acc[q][i+1];
                        m_ser[q][i] = m_ser[q][i+1]; m_end[q][i] = m_end[q][i+1];
                    end
                    m_cnt[q]--;
                end
            end
            // Then the write decided on the state before this cycle.
            if (v && exp_rdy) begin
                if (st || pre_hit) begin
                    if (st) begin
                        serial++;
                        mp_v[acc] = 1'b1; mp_q[acc] = tq; mp_ser[acc] = serial;
                        pre_ser = serial;
                    end
                    m_pl[tq][m_cnt[tq]]  = pl_ctr & 16'hFFFF;
                    m_acc[tq][m_cnt[tq]] = acc;
                    m_ser[tq][m_cnt[tq]] = pre_ser;
                    m_end[tq][m_cnt[tq]] = en;
                    m_cnt[tq]++;
                    m_tail[tq] = en;
                end else begin
                    m_err = 1'b1;
                end
            end
        end
        @(posedge clk);
    endtask

    task automatic idle(input logic [NQ-1:0] rdy);
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, rdy);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        serial = 0;
        pl_ctr = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        idle('0);
        // R7: unmapped follower is taken, dropped and flagged.
        step(0, 1, 0, 0, 2, '0);
        idle('0);
        // R9 then R1: flush blocks input and clears the flag.
        step(1, 1, 1, 0, 0, '0);
        idle('0);
        // R2: starts land in the lowest empty FIFOs.
        step(0, 1, 1, 0, 0, '0);
        step(0, 1, 1, 1, 1, '0);
        // R4 R6: followers fill FIFO 0, then one more stalls.
        for (int i = 0; i < 7; i++) step(0, 1, 0, 0, 0, '0);
        step(0, 1, 0, 0, 0, 4'b0001);
        step(0, 1, 0, 0, 0, '0);
        // R3: reuse of an end-marked tail, then stall with none left.
        step(0, 1, 1, 1, 2, '0);
        step(0, 1, 1, 0, 3, '0);
        step(0, 1, 1, 0, 4, '0);
        step(0, 1, 1, 0, 5, '0);
        step(0, 1, 1, 0, 6, '0);
        // R5: drain everything in order.
        for (int i = 0; i < 12; i++) idle('1);

        // R8: a closing pop and a new start on the same accumulator collide.
        step(1, 0, 0, 0, 0, '0);
        step(0, 1, 1, 1, 3, '0);
        step(0, 1, 1, 0, 3, 4'b0001);
        step(0, 1, 0, 1, 3, '0);
        idle('0);
        // R8: a closing pop without a remap releases the mapping.
        step(1, 0, 0, 0, 0, '0);
        step(0, 1, 1, 1, 4, '0);
        idle(4'b0001);
        step(0, 1, 0, 0, 4, '0);
        idle('0);
        step(1, 0, 0, 0, 0, '0);

        // Seeded random traffic.
        for (int n = 0; n < 4000; n++) begin
            int a;
            bit s, e, v, f;
            logic [NQ-1:0] r;
            a = int'($urandom % NA);
            s = mp_v[a] ? ($urandom % 10 < 2) : ($urandom % 20 < 19);
            e = ($urandom % 10 < 3);
            v = ($urandom % 10 < 8);
            f = ($urandom % 300 == 0);
            for (int q = 0; q < NQ; q++) r[q] = ($urandom % 10 < 5);
            step(f, v, s, e, a, r);
        end
        for (int i = 0; i < 12; i++) idle('1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule